// File: doc/BRIEF.md
# Configurable Asynchronous Serial Receiver

This block is the receive side of an asynchronous serial port. It watches one serial input line and counts pulses of an oversampling tick supplied by an external rate generator. From the line it recovers frames of 5 to 9 data bits, an optional parity bit and one or two stop bits, and it presents each frame as a parallel word. A receive-complete flag tells the consumer that a word is ready. A one-cycle read strobe takes the word and clears the flag.

Each bit is decided by a three-sample majority vote around its centre. This rejects short noise pulses. It also rejects falling edges that do not last long enough to form a real start bit. The framing and parity results are stored together with the word they belong to. An overrun flag reports that a frame arrived before the previous word was read. In the multi-processor addressing mode, frames that are not marked as addresses are silently dropped. This lets a listener sleep through traffic meant for other nodes.

Top module: `async_frame_receiver`

## Requirements
- R1: The data width follows `cfg_data_bits`. Values 5 to 9 are used as given, values below 5 act as 5 and values above 9 act as 9. Bits arrive least-significant first and appear right-aligned on `rx_data`, with unused upper bits at zero.
- R2: `cfg_parity` bit 1 enables a parity bit after the data bits, and bit 0 selects odd (1) or even (0). With even parity the data ones plus the parity bit must be even, and with odd parity they must be odd. A mismatch sets `rx_parity_err` for that word. With parity disabled no parity bit is expected and `rx_parity_err` stays 0.
- R3: A first stop bit that is sampled low sets `rx_frame_err` for that word. When `cfg_two_stop` is 1, a second stop bit is expected but its value never raises an error.
- R4: If a frame completes while `rx_valid` is 1 and `rd_ack` is not asserted, the held word and its flags are kept, the new frame is lost and `rx_overrun` goes to 1. A cycle with `rd_ack` and no completing frame clears both `rx_valid` and `rx_overrun`.
- R5: A falling edge whose start-bit majority vote reads high is a false start. The receiver returns to idle and produces no word.
- R6: Every bit value is the majority of three consecutive tick samples at the bit centre. A line inversion that lasts for only one of those samples does not change the received value.
- R7: With `cfg_double_speed` at 0 a bit lasts 16 ticks and is voted on ticks 7, 8 and 9 of the bit. With `cfg_double_speed` at 1 a bit lasts 8 ticks and is voted on ticks 3, 4 and 5.
- R8: When `cfg_mp_mode` is 1, a frame whose most-significant configured data bit (bit 8 for 9-bit frames) is 0 is discarded. It leaves `rx_valid`, `rx_data`, the error flags and `rx_overrun` unchanged. A frame with that bit at 1 is delivered normally.
- R9: `rx_frame_err` and `rx_parity_err` belong to the word on `rx_data`. They stay unchanged until that word is replaced, including while an overrunning frame is being lost.
- R10: After a synchronous reset, `rx_valid`, `rx_overrun`, `rx_frame_err` and `rx_parity_err` are 0 and `rx_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_tick | input | 1 | One-cycle oversampling pulse from the rate generator |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| cfg_data_bits | input | 4 | Data bits per frame (5 to 9) |
| cfg_parity | input | 2 | Bit 1 enables parity, bit 0 selects odd |
| cfg_two_stop | input | 1 | Expect two stop bits |
| cfg_double_speed | input | 1 | Use 8 ticks per bit instead of 16 |
| cfg_mp_mode | input | 1 | Drop frames not marked as address frames |
| rd_ack | input | 1 | Consumer has taken the held word |
| rx_valid | output | 1 | A received word is waiting |
| rx_data | output | 9 | Received word, right-aligned |
| rx_frame_err | output | 1 | The held word had a low first stop bit |
| rx_parity_err | output | 1 | The held word failed its parity check |
| rx_overrun | output | 1 | A frame was lost while a word was waiting |

## Verification
The hardest cases to reach are the ones where the line misbehaves for exactly one oversampling tick. Examples are an inverted sample in the middle of a voted window, or a falling edge that recovers before the start-bit vote. The driver therefore paces the line by the tick itself, one tick per sample, rather than by wall time. It can then invert the line on a chosen tick of a chosen bit, in both normal and double-speed modes. Overrun and error retention are reached by switching off the monitor's automatic reads. Two frames are then sent back to back, and the flags are inspected before the held word is finally read.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam int DATA_W   = 9;
    localparam int BITS_MIN = 5;
    localparam int BITS_MAX = 9;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP1,
        ST_STOP2
    } rx_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              frame_err;
        logic              parity_err;
    } rx_word_t;

    // Clamp the requested width into the supported range.
    function automatic logic [3:0] eff_bits(input logic [3:0] sel);
        if (sel < 4'(BITS_MIN)) return 4'(BITS_MIN);
        if (sel > 4'(BITS_MAX)) return 4'(BITS_MAX);
        return sel;
    endfunction

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/rxf_sync.sv
module rxf_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/rxf_bit_sampler.sv
module rxf_bit_sampler #(
    parameter int OSR = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic line,
    input  logic dbl,
    input  logic run,
    output logic smp_done,
    output logic smp_bit,
    output logic bit_end
);
    import rxf_pkg::*;

    localparam int CW   = $clog2(OSR);
    localparam int HALF = OSR / 2;

    logic [CW-1:0] cnt;
    logic [CW-1:0] last;
    logic [CW-1:0] mid;
    logic [CW-1:0] mid_lo;
    logic [CW-1:0] mid_hi;
    logic          v0, v1;

    always_comb begin
        last   = dbl ? CW'(HALF - 1) : CW'(OSR - 1);
        mid    = dbl ? CW'(HALF / 2) : CW'(HALF);
        mid_lo = mid - CW'(1);
        mid_hi = mid + CW'(1);
    end

    // The tick that detected the start edge is position 0, so counting resumes at 1.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= CW'(1);
            v0  <= 1'b1;
            v1  <= 1'b1;
        end else if (!run) begin
            cnt <= CW'(1);
        end else if (tick) begin
            if (cnt == mid_lo) v0 <= line;
            if (cnt == mid)    v1 <= line;
            cnt <= (cnt == last) ? '0 : cnt + CW'(1);
        end
    end

    assign smp_done = run && tick && (cnt == mid_hi);
    assign smp_bit  = maj3(v0, v1, line);
    assign bit_end  = run && tick && (cnt == last);

    AST_CNT_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (run && $stable(dbl)) |-> (cnt <= last)) else $error("bit counter past bit end"); // R7
endmodule

// File: rtl/rxf_frame_fsm.sv
module rxf_frame_fsm (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              line,
    input  logic [3:0]        nbits,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              two_stop,
    input  logic              smp_done,
    input  logic              smp_bit,
    input  logic              bit_end,
    output logic              run,
    output logic              done,
    output rxf_pkg::rx_word_t word
);
    import rxf_pkg::*;

    rx_state_e         state;
    logic [DATA_W-1:0] shreg;
    logic [3:0]        idx;
    logic              perr;
    logic              ferr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            shreg <= '0;
            idx   <= '0;
            perr  <= 1'b0;
            ferr  <= 1'b0;
            done  <= 1'b0;
            word  <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (tick && !line) begin
                        state <= ST_START;
                        shreg <= '0;
                        idx   <= '0;
                        perr  <= 1'b0;
                        ferr  <= 1'b0;
                    end
                end
                ST_START: begin
                    if (smp_done && smp_bit)  state <= ST_IDLE;
                    else if (bit_end)         state <= ST_DATA;
                end
                ST_DATA: begin
                    if (smp_done) shreg[idx] <= smp_bit;
                    if (bit_end) begin
                        if (idx == nbits - 4'd1) state <= par_en ? ST_PARITY : ST_STOP1;
                        else                     idx   <= idx + 4'd1;
                    end
                end
                ST_PARITY: begin
                    if (smp_done) perr  <= ((^shreg) ^ smp_bit) != par_odd;
                    if (bit_end)  state <= ST_STOP1;
                end
                ST_STOP1: begin
                    if (smp_done) begin
                        if (two_stop) begin
                            ferr <= !smp_bit;
                        end else begin
                            done  <= 1'b1;
                            word  <= '{data: shreg, frame_err: !smp_bit, parity_err: perr};
                            state <= ST_IDLE;
                        end
                    end else if (bit_end && two_stop) begin
                        state <= ST_STOP2;
                    end
                end
                ST_STOP2: begin
                    if (smp_done) begin
                        done  <= 1'b1;
                        word  <= '{data: shreg, frame_err: ferr, parity_err: perr};
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign run = (state != ST_IDLE);

    AST_FALSE_START_IDLE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_START && smp_done && smp_bit) |=> (state == ST_IDLE && !done)) else $error("false start not dropped"); // R5
endmodule

// File: rtl/rxf_result_hold.sv
module rxf_result_hold (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  rxf_pkg::rx_word_t word_in,
    input  logic              rd_ack,
    output logic              valid,
    output logic              overrun,
    output rxf_pkg::rx_word_t word_out
);
    import rxf_pkg::*;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid    <= 1'b0;
            overrun  <= 1'b0;
            word_out <= '0;
        end else if (accept) begin
            if (valid && !rd_ack) begin
                overrun <= 1'b1;
            end else begin
                word_out <= word_in;
                valid    <= 1'b1;
                overrun  <= 1'b0;
            end
        end else if (rd_ack) begin
            valid   <= 1'b0;
            overrun <= 1'b0;
        end
    end

    AST_OVERRUN_KEEPS_WORD: assert property (@(posedge clk) disable iff (rst)
        (valid && accept && !rd_ack) |=> (overrun && $stable(word_out))) else $error("overrun lost held word"); // R4
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rd_ack && !accept) |=> (!valid && !overrun)) else $error("read did not clear"); // R4
    AST_OVR_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        overrun |-> valid) else $error("overrun without word"); // R4
    AST_FLAGS_HELD: assert property (@(posedge clk) disable iff (rst)
        (valid && !rd_ack) |=> $stable(word_out)) else $error("flags changed while held"); // R9
endmodule

// File: rtl/async_frame_receiver.sv
module async_frame_receiver #(
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sample_tick,
    input  logic       rx_line,
    input  logic [3:0] cfg_data_bits,
    input  logic [1:0] cfg_parity,
    input  logic       cfg_two_stop,
    input  logic       cfg_double_speed,
    input  logic       cfg_mp_mode,
    input  logic       rd_ack,
    output logic       rx_valid,
    output logic [8:0] rx_data,
    output logic       rx_frame_err,
    output logic       rx_parity_err,
    output logic       rx_overrun
);
    import rxf_pkg::*;

    logic       line_s;
    logic       run;
    logic       smp_done, smp_bit, bit_end;
    logic       frm_done;
    logic [3:0] nbits;
    logic       mp_flag;
    logic       accept;
    rx_word_t   frm_word;
    rx_word_t   held_word;

    assign nbits = eff_bits(cfg_data_bits);

    rxf_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rx_line),
        .dout (line_s)
    );

    rxf_bit_sampler #(.OSR(OSR)) u_sampler (
        .clk      (clk),
        .rst      (rst),
        .tick     (sample_tick),
        .line     (line_s),
        .dbl      (cfg_double_speed),
        .run      (run),
        .smp_done (smp_done),
        .smp_bit  (smp_bit),
        .bit_end  (bit_end)
    );

    rxf_frame_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .tick     (sample_tick),
        .line     (line_s),
        .nbits    (nbits),
        .par_en   (cfg_parity[1]),
        .par_odd  (cfg_parity[0]),
        .two_stop (cfg_two_stop),
        .smp_done (smp_done),
        .smp_bit  (smp_bit),
        .bit_end  (bit_end),
        .run      (run),
        .done     (frm_done),
        .word     (frm_word)
    );

    // Address marker is the top configured data bit.
    assign mp_flag = frm_word.data[nbits - 4'd1];
    assign accept  = frm_done && (!cfg_mp_mode || mp_flag);

    rxf_result_hold u_hold (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .word_in  (frm_word),
        .rd_ack   (rd_ack),
        .valid    (rx_valid),
        .overrun  (rx_overrun),
        .word_out (held_word)
    );

    assign rx_data       = held_word.data;
    assign rx_frame_err  = held_word.frame_err;
    assign rx_parity_err = held_word.parity_err;

    AST_MP_DISCARD: assert property (@(posedge clk) disable iff (rst)
        (cfg_mp_mode && frm_done && !mp_flag && !rd_ack) |=>
        ($stable(rx_valid) && $stable(rx_data) && $stable(rx_overrun))) else $error("data frame not dropped"); // R8
endmodule

// File: tb/test_async_frame_receiver.sv
module test_async_frame_receiver;

    typedef struct {
        logic [8:0] data;
        logic       fe;
        logic       pe;
        string      req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       line = 1'b1;
    logic [3:0] cfg_bits = 4'd8;
    logic [1:0] cfg_par = 2'b00;
    logic       cfg_two = 1'b0;
    logic       cfg_dbl = 1'b0;
    logic       cfg_mp = 1'b0;
    logic       rd_ack = 1'b0;
    logic       rx_valid, rx_frame_err, rx_parity_err, rx_overrun;
    logic [8:0] rx_data;

    int   total = 0;
    int   bad = 0;
    bit   auto_read = 1'b1;
    int   man_req = 0;
    int   man_seen = 0;
    bit   finished = 1'b0;
    exp_t exp_q[$];
    logic [1:0] tdiv = 2'd0;

    always #2 clk = ~clk;

    always @(posedge clk) begin
        tdiv <= tdiv + 2'd1;
        tick <= (tdiv == 2'd3);
    end

    async_frame_receiver i_async_frame_receiver (
        .clk              (clk),
        .rst              (rst),
        .sample_tick      (tick),
        .rx_line          (line),
        .cfg_data_bits    (cfg_bits),
        .cfg_parity       (cfg_par),
        .cfg_two_stop     (cfg_two),
        .cfg_double_speed (cfg_dbl),
        .cfg_mp_mode      (cfg_mp),
        .rd_ack           (rd_ack),
        .rx_valid         (rx_valid),
        .rx_data          (rx_data),
        .rx_frame_err     (rx_frame_err),
        .rx_parity_err    (rx_parity_err),
        .rx_overrun       (rx_overrun)
    );

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic wait_tick();
        do @(posedge clk); while (!tick);
        @(negedge clk);
    endtask

    function automatic int osr();
        return cfg_dbl ? 8 : 16;
    endfunction

    // One bit lasts osr ticks; glitch inverts the centre voted sample.
    task automatic drive_bit(input logic v, input bit glitch);
        for (int t = 1; t <= osr(); t++) begin
            line = (glitch && t == osr() / 2 + 1) ? ~v : v;
            wait_tick();
        end
    endtask

    task automatic send_frame(input logic [8:0] d, input bit bad_par, input logic stop1,
                              input logic stop2, input int glitch_bit, input bit expect_out,
                              input string req);
        int nb;
        logic [8:0] dm;
        logic pbit;
        exp_t e;
        nb = (cfg_bits < 5) ? 5 : (cfg_bits > 9) ? 9 : int'(cfg_bits);
        dm = d & 9'((1 << nb) - 1);
        pbit = (^dm) ^ cfg_par[0] ^ bad_par;
        if (expect_out) begin
            e.data = dm;
            e.fe = ~stop1;
            e.pe = cfg_par[1] & bad_par;
            e.req = req;
            exp_q.push_back(e);
        end
        drive_bit(1'b0, glitch_bit == -2);
        for (int i = 0; i < nb; i++) drive_bit(dm[i], glitch_bit == i);
        if (cfg_par[1]) drive_bit(pbit, 1'b0);
        drive_bit(stop1, 1'b0);
        if (cfg_two) drive_bit(stop2, 1'b0);
        drive_bit(1'b1, 1'b0);
        drive_bit(1'b1, 1'b0);
    endtask

    // Monitor: pop expected items as words appear and release them.
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (!rst && rx_valid && (auto_read || man_req != man_seen)) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5/R8 unexpected word", 16'(rx_data), 16'h0);
                end else begin
                    e = exp_q.pop_front();
                    check(rx_data == e.data && rx_frame_err == e.fe && rx_parity_err == e.pe,
                          e.req, {5'd0, rx_data, rx_frame_err, rx_parity_err},
                          {5'd0, e.data, e.fe, e.pe});
                end
                man_seen = man_req;
                rd_ack = 1'b1;
                @(negedge clk);
                rd_ack = 1'b0;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(rx_valid == 0 && rx_overrun == 0, "R10 flags", {14'd0, rx_valid, rx_overrun}, 16'h0);
        check(rx_data == 0 && rx_frame_err == 0 && rx_parity_err == 0, "R10 word",
              {5'd0, rx_data, rx_frame_err, rx_parity_err}, 16'h0);

        // R1 widths and ordering
        cfg_bits = 4'd8;
        send_frame(9'h0A5, 0, 1, 1, -1, 1, "R1 8 bits a5");
        send_frame(9'h03C, 0, 1, 1, -1, 1, "R1 8 bits 3c");
        cfg_bits = 4'd5;
        send_frame(9'h1B5, 0, 1, 1, -1, 1, "R1 5 bits");
        cfg_bits = 4'd6;
        send_frame(9'h02D, 0, 1, 1, -1, 1, "R1 6 bits");
        cfg_bits = 4'd7;
        send_frame(9'h061, 0, 1, 1, -1, 1, "R1 7 bits");
        cfg_bits = 4'd9;
        send_frame(9'h1A5, 0, 1, 1, -1, 1, "R1 9 bits");
        cfg_bits = 4'd2;
        send_frame(9'h0F3, 0, 1, 1, -1, 1, "R1 clamp low to 5");

        // R2 parity
        cfg_bits = 4'd8;
        cfg_par = 2'b10;
        send_frame(9'h0B7, 0, 1, 1, -1, 1, "R2 even good");
        send_frame(9'h0B7, 1, 1, 1, -1, 1, "R2 even bad");
        cfg_par = 2'b11;
        send_frame(9'h046, 0, 1, 1, -1, 1, "R2 odd good");
        send_frame(9'h046, 1, 1, 1, -1, 1, "R2 odd bad");
        cfg_par = 2'b00;

        // R3 stop bits
        send_frame(9'h05A, 0, 0, 1, -1, 1, "R3 low stop1");
        cfg_two = 1'b1;
        send_frame(9'h0C3, 0, 1, 0, -1, 1, "R3 low stop2 ignored");
        send_frame(9'h0C4, 0, 0, 1, -1, 1, "R3 two stop low stop1");
        cfg_two = 1'b0;

        // R5 false start: low only for the first four ticks
        for (int t = 1; t <= 16; t++) begin
            line = (t <= 4) ? 1'b0 : 1'b1;
            wait_tick();
        end
        drive_bit(1'b1, 1'b0);
        check(rx_valid == 0, "R5 no word after false start", 16'(rx_valid), 16'h0);
        send_frame(9'h099, 0, 1, 1, -1, 1, "R5 recovery frame");

        // R6 single-sample glitches
        send_frame(9'h055, 0, 1, 1, 3, 1, "R6 glitch data bit");
        send_frame(9'h0AA, 0, 1, 1, -2, 1, "R6 glitch start bit");

        // R7 double speed
        cfg_dbl = 1'b1;
        send_frame(9'h0E1, 0, 1, 1, -1, 1, "R7 double speed");
        send_frame(9'h01E, 0, 1, 1, 5, 1, "R7 double speed glitch");
        cfg_dbl = 1'b0;

        // R8 multi-processor filtering
        cfg_bits = 4'd9;
        cfg_mp = 1'b1;
        send_frame(9'h0AA, 0, 1, 1, -1, 0, "R8 data dropped");
        check(rx_valid == 0, "R8 no word for data frame", 16'(rx_valid), 16'h0);
        send_frame(9'h1C3, 0, 1, 1, -1, 1, "R8 address accepted");
        cfg_mp = 1'b0;
        cfg_bits = 4'd8;

        // R4 and R9: overrun with held parity error
        auto_read = 1'b0;
        cfg_par = 2'b10;
        send_frame(9'h033, 1, 1, 1, -1, 1, "R9 held word");
        send_frame(9'h044, 0, 1, 1, -1, 0, "R4 lost frame");
        check(rx_valid == 1 && rx_overrun == 1, "R4 overrun set", {14'd0, rx_valid, rx_overrun}, 16'h3);
        check(rx_data == 9'h033, "R4 old word kept", 16'(rx_data), 16'h033);
        check(rx_parity_err == 1, "R9 error held", 16'(rx_parity_err), 16'h1);
        man_req++;
        repeat (8) @(negedge clk);
        check(rx_valid == 0 && rx_overrun == 0, "R4 read clears", {14'd0, rx_valid, rx_overrun}, 16'h0);
        cfg_par = 2'b00;
        auto_read = 1'b1;

        repeat (50) @(negedge clk);
        check(exp_q.size() == 0, "R1 all words delivered", 16'(exp_q.size()), 16'h0);
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule